// File: doc/BRIEF.md
# Routed Local Interrupt Controller

This block gathers 32 interrupt sources, qualifies each according to its own trigger setting, and steers it toward one of four processor cores and one of four parent interrupt lines. Each source can be set to level or edge sensing, in either polarity. A source that is pending and enabled appears in the status word of every core its routing byte selects, and it drives every parent line that byte selects.

Software configures the block through a simple register port. The port accepts single-cycle word writes with byte enables, and reads are combinational. Each source has a routing byte. Enable bits are changed through separate set and clear registers, so no read-modify-write is needed. Polarity and trigger mode are held in two 32-bit bitmaps. Software finds out which sources need service by reading the per-core status words. For an edge-sensed source it writes the clear register, which drops the captured event along with the enable.

The address is a byte address. All accesses are word-aligned. A source's routing byte sits at byte offset equal to its index: word offset 4·(i/4), byte lane i%4.

Top module: `rlic_top`

## Requirements
- R1: After reset, all enable bits are 0, the polarity and edge bitmaps are 0, every routing byte is 0x00, all parent outputs are low and every status word reads 0.
- R2: The routing byte of source i is written and read at byte lane i%4 of the word at offset 4·(i/4) (offsets 0x00–0x1C). Only lanes whose byte enable is 1 are written. Bits [3:0] of the byte select cores 0–3, and bits [7:4] select parent lines 0–3.
- R3: A write to offset 0x28 sets each enable bit whose data bit (under an active byte lane) is 1 and leaves the others unchanged. The enable word reads back at 0x24.
- R4: A write to offset 0x2C clears each enable bit whose data bit (under an active byte lane) is 1 and leaves the others unchanged.
- R5: In level mode (edge bit 0), a source is pending while its input XOR its polarity bit is 1. A change on the input reaches the outputs two clock edges after it is applied, through a two-flop synchroniser.
- R6: In edge mode (edge bit 1), a synchronised rising edge (polarity 0) or falling edge (polarity 1) sets a pending latch. The latch holds after the input returns.
- R7: The edge latch of a source is cleared by writing 1 to that source's bit at offset 0x2C. Enabling the source again afterwards does not restore the event. The latch is also held clear while the source is in level mode.
- R8: The status word of core n, read at 0x40 + 8·n, has bit i set exactly when source i is pending, enabled, and has routing bit n set.
- R9: Parent output k is high exactly when at least one source is pending, enabled, and has routing bit 4+k set.
- R10: Reads of unmapped offsets read 0. This includes 0x20, 0x28, 0x2C, the gaps between status words, and any address whose low two bits are not zero. Writes to unmapped or read-only offsets (0x24, status words) and misaligned writes change nothing.
- R11: The polarity bitmap is written and read at 0x30, and the edge bitmap at 0x34, with byte-enable merging.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_src | input | 32 | Asynchronous interrupt source inputs |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 8 | Register byte address, shared by reads and writes |
| reg_be | input | 4 | Byte enables for writes |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| par_irq | output | 4 | Parent interrupt lines |

## Verification
The hardest case to reach from the ports is an edge latch that must outlive its input. The captured event has to survive the input returning to its idle level. It then has to vanish on a disable write, and stay gone when the source is enabled again. It also has to interact correctly with polarity and mode changes made while the input is held. The stimulus reaches this case in two ways. Directed sequences pulse sources in both polarities, then clear and re-enable them. A seeded random phase interleaves routing, enable, polarity, mode and input changes, with the input held steady for several cycles around each step. A bench model tracks which transitions should have been caught, and every status word and parent line is compared against that model after each step.

// File: rtl/rlic_pkg.sv
// Package: shared constants, the routing byte type and address decode helpers
// for the routed local interrupt controller. Assumes an 8-bit byte address and
// a 32-bit data word; word offsets below are byte offsets divided by four.
package rlic_pkg;

    localparam int NUM_SRC     = 32;
    localparam int NUM_CORE    = 4;
    localparam int NUM_PAR     = 4;
    localparam int DATA_W      = 32;
    localparam int ADDR_W      = 8;
    localparam int WORD_AW     = ADDR_W - 2;
    localparam int LANES       = DATA_W / 8;
    localparam int ROUTE_WORDS = NUM_SRC / LANES;
    localparam int PAR_SHIFT   = 4;

    // Word offsets of the control registers
    localparam int W_ENABLE    = 9;   // 0x24 enable readback
    localparam int W_SET       = 10;  // 0x28 enable set
    localparam int W_CLR       = 11;  // 0x2C enable clear
    localparam int W_POL       = 12;  // 0x30 polarity bitmap
    localparam int W_EDGE      = 13;  // 0x34 edge bitmap
    localparam int W_STAT0     = 16;  // 0x40 first core status word
    localparam int STAT_STEP   = 2;   // 8-byte spacing between status words

    // Routing byte: low nibble selects cores, high nibble selects parent lines
    typedef logic [7:0] route_t;

    // Return the core index addressed by a word offset, or -1
    function automatic int stat_core(input logic [WORD_AW-1:0] w);
        int r;
        r = -1;
        for (int c = 0; c < NUM_CORE; c++) begin
            if (int'(w) == W_STAT0 + STAT_STEP * c) r = c;
        end
        return r;
    endfunction

    // True when a byte address reads a defined register
    function automatic logic rd_mapped(input logic [ADDR_W-1:0] a);
        logic [WORD_AW-1:0] w;
        w = a[ADDR_W-1:2];
        if (a[1:0] != 2'b00) return 1'b0;
        return (int'(w) < ROUTE_WORDS) || (int'(w) == W_ENABLE) ||
               (int'(w) == W_POL) || (int'(w) == W_EDGE) ||
               (stat_core(w) >= 0);
    endfunction

endpackage

// File: rtl/rlic_src_cell.sv
// Module: per-source capture cell. Synchronises one asynchronous interrupt
// input through two flops, then produces a pending flag: in level mode the
// polarity-adjusted synchronised value, in edge mode a latch set on the
// selected edge. Assumes clr_i is a one-cycle pulse from the clear register
// and that the input is held for at least one clock to be seen.
module rlic_src_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    input  logic pol_i,
    input  logic edge_mode_i,
    input  logic clr_i,
    output logic pend_o,
    output logic lat_o
);

    logic sync1_q, sync2_q, prev_q;
    logic lat_q;
    logic rise, fall, hit;

    // Two-flop synchroniser plus one history flop for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1_q <= 1'b0;
            sync2_q <= 1'b0;
            prev_q  <= 1'b0;
        end else begin
            sync1_q <= raw_i;
            sync2_q <= sync1_q;
            prev_q  <= sync2_q;
        end
    end

    // Edge selection on the raw synchronised level so polarity changes alone never fire
    always_comb begin
        rise = sync2_q & ~prev_q;
        fall = ~sync2_q & prev_q;
        hit  = pol_i ? fall : rise;
    end

    // Edge latch: cleared by disable write or level mode, set by the selected edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= 1'b0;
        end else if (clr_i || !edge_mode_i) begin
            lat_q <= 1'b0;
        end else if (hit) begin
            lat_q <= 1'b1;
        end
    end

    // Pending selection between the two trigger modes
    always_comb begin
        pend_o = edge_mode_i ? lat_q : (sync2_q ^ pol_i);
        lat_o  = lat_q;
    end

endmodule

// File: rtl/rlic_regfile.sv
// Module: register block. Holds routing bytes, the enable word, and the
// polarity and edge bitmaps; decodes single-cycle writes with byte enables
// and returns combinational read data. Assumes core status words are computed
// outside and passed in. Misaligned accesses are treated as unmapped.
module rlic_regfile
    import rlic_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [LANES-1:0]    reg_be,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic [NUM_SRC-1:0]  core_stat [NUM_CORE],
    output logic [DATA_W-1:0]   reg_rdata,
    output route_t              route_o   [NUM_SRC],
    output logic [NUM_SRC-1:0]  en_o,
    output logic [NUM_SRC-1:0]  pol_o,
    output logic [NUM_SRC-1:0]  edge_o,
    output logic [NUM_SRC-1:0]  clr_pulse_o
);

    logic [WORD_AW-1:0] word;
    logic               aligned;
    logic               wr_ok;
    logic [DATA_W-1:0]  lane_mask;
    logic [DATA_W-1:0]  wmask_data;
    logic [NUM_SRC-1:0] en_q, pol_q, edge_q;
    route_t             route_q [NUM_SRC];

    // Address split and byte-enable expansion
    always_comb begin
        word    = reg_addr[ADDR_W-1:2];
        aligned = (reg_addr[1:0] == 2'b00);
        wr_ok   = reg_wr && aligned;
        for (int b = 0; b < LANES; b++) begin
            lane_mask[8*b +: 8] = {8{reg_be[b]}};
        end
        wmask_data = reg_wdata & lane_mask;
    end

    // Routing byte storage: one register per source, written through its lane
    for (genvar rw = 0; rw < ROUTE_WORDS; rw++) begin : g_rword
        for (genvar b = 0; b < LANES; b++) begin : g_lane
            localparam int IDX = rw * LANES + b;
            // Byte write of one routing register
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    route_q[IDX] <= '0;
                end else if (wr_ok && int'(word) == rw && reg_be[b]) begin
                    route_q[IDX] <= reg_wdata[8*b +: 8];
                end
            end
            assign route_o[IDX] = route_q[IDX];
        end
    end

    // Enable word updated by the set and clear registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (wr_ok && int'(word) == W_SET) begin
            en_q <= en_q | wmask_data;
        end else if (wr_ok && int'(word) == W_CLR) begin
            en_q <= en_q & ~wmask_data;
        end
    end

    // Polarity bitmap with byte-lane merge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_q <= '0;
        end else if (wr_ok && int'(word) == W_POL) begin
            pol_q <= (pol_q & ~lane_mask) | wmask_data;
        end
    end

    // Edge bitmap with byte-lane merge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= '0;
        end else if (wr_ok && int'(word) == W_EDGE) begin
            edge_q <= (edge_q & ~lane_mask) | wmask_data;
        end
    end

    // Clear pulse toward the edge latches, same cycle as the enable clear
    always_comb begin
        clr_pulse_o = (wr_ok && int'(word) == W_CLR) ? wmask_data : '0;
    end

    // Combinational read multiplexer; unmapped words read zero
    always_comb begin
        reg_rdata = '0;
        if (aligned) begin
            for (int rw = 0; rw < ROUTE_WORDS; rw++) begin
                if (int'(word) == rw) begin
                    for (int b = 0; b < LANES; b++) begin
                        reg_rdata[8*b +: 8] = route_q[rw * LANES + b];
                    end
                end
            end
            if (int'(word) == W_ENABLE) reg_rdata = en_q;
            if (int'(word) == W_POL)    reg_rdata = pol_q;
            if (int'(word) == W_EDGE)   reg_rdata = edge_q;
            for (int c = 0; c < NUM_CORE; c++) begin
                if (int'(word) == W_STAT0 + STAT_STEP * c) reg_rdata = core_stat[c];
            end
        end
    end

    // Register outputs toward the datapath
    always_comb begin
        en_o   = en_q;
        pol_o  = pol_q;
        edge_o = edge_q;
    end

endmodule

// File: rtl/rlic_fanout.sv
// Module: routing fan-out. Masks pending sources with their enables, then
// builds one status word per core from the low routing nibble and one parent
// line per output from the high nibble. Purely combinational.
module rlic_fanout
    import rlic_pkg::*;
(
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] en_i,
    input  route_t             route_i [NUM_SRC],
    output logic [NUM_SRC-1:0] active_o,
    output logic [NUM_SRC-1:0] core_stat_o [NUM_CORE],
    output logic [NUM_PAR-1:0] par_o
);

    // Enabled and pending sources
    assign active_o = pend_i & en_i;

    // One status word per core
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        // Gather the sources that select core c
        always_comb begin
            for (int i = 0; i < NUM_SRC; i++) begin
                core_stat_o[c][i] = active_o[i] & route_i[i][c];
            end
        end
    end

    // One OR-reduced parent line per output
    for (genvar k = 0; k < NUM_PAR; k++) begin : g_par
        logic [NUM_SRC-1:0] col;
        // Collect the sources that select parent line k, then reduce
        always_comb begin
            for (int i = 0; i < NUM_SRC; i++) begin
                col[i] = route_i[i][PAR_SHIFT + k];
            end
            par_o[k] = |(active_o & col);
        end
    end

endmodule

// File: rtl/rlic_top.sv
// Module: top of the routed local interrupt controller. Instantiates one
// capture cell per source, the register block and the routing fan-out.
// Assumes a single clock domain for the register port; the source inputs
// may be asynchronous.
module rlic_top
    import rlic_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  irq_src,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [LANES-1:0]    reg_be,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [NUM_PAR-1:0]  par_irq
);

    route_t             route [NUM_SRC];
    logic [NUM_SRC-1:0] en, pol, edge_mode, clr_pulse;
    logic [NUM_SRC-1:0] pend, edge_lat, active;
    logic [NUM_SRC-1:0] core_stat [NUM_CORE];

    // Per-source synchronisation and trigger capture
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        rlic_src_cell u_cell (
            .clk         (clk),
            .rst_n       (rst_n),
            .raw_i       (irq_src[i]),
            .pol_i       (pol[i]),
            .edge_mode_i (edge_mode[i]),
            .clr_i       (clr_pulse[i]),
            .pend_o      (pend[i]),
            .lat_o       (edge_lat[i])
        );
    end

    rlic_regfile u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr      (reg_wr),
        .reg_addr    (reg_addr),
        .reg_be      (reg_be),
        .reg_wdata   (reg_wdata),
        .core_stat   (core_stat),
        .reg_rdata   (reg_rdata),
        .route_o     (route),
        .en_o        (en),
        .pol_o       (pol),
        .edge_o      (edge_mode),
        .clr_pulse_o (clr_pulse)
    );

    rlic_fanout u_fan (
        .pend_i      (pend),
        .en_i        (en),
        .route_i     (route),
        .active_o    (active),
        .core_stat_o (core_stat),
        .par_o       (par_irq)
    );

endmodule

// File: rtl/rlic_checker.sv
// Module: property checker for rlic_top, attached by bind. Observes the
// register port, the enable word, the edge latches and the active vector.
module rlic_checker
    import rlic_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic [ADDR_W-1:0]   reg_addr,
    input  logic [LANES-1:0]    reg_be,
    input  logic [DATA_W-1:0]   reg_wdata,
    input  logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_PAR-1:0]  par_irq,
    input  logic [NUM_SRC-1:0]  en,
    input  logic [NUM_SRC-1:0]  edge_lat,
    input  logic [NUM_SRC-1:0]  active
);

    logic [DATA_W-1:0] mask;
    logic              wr_set, wr_clr, wr_other;

    // Decode of the observed write, independent of the register block
    always_comb begin
        for (int b = 0; b < LANES; b++) begin
            mask[8*b +: 8] = reg_wdata[8*b +: 8] & {8{reg_be[b]}};
        end
        wr_set   = reg_wr && reg_addr == 8'h28;
        wr_clr   = reg_wr && reg_addr == 8'h2C;
        wr_other = reg_wr && !wr_set && !wr_clr;
    end

    p_set_sticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_set |=> ((en & $past(mask)) == $past(mask)));

    p_clear_sticks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((en & $past(mask)) == '0));

    p_latch_dropped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_clr |=> ((edge_lat & $past(mask)) == '0));

    p_par_has_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (par_irq != '0) |-> (active != '0));

    p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_mapped(reg_addr) |-> (reg_rdata == '0));

    p_enable_kept_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_other |=> $stable(en));

endmodule

bind rlic_top rlic_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_be    (reg_be),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .par_irq   (par_irq),
    .en        (en),
    .edge_lat  (edge_lat),
    .active    (active)
);

// File: tb/rlic_top_tb_top.sv
module rlic_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_src = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [3:0]  reg_be = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  par_irq;

    int n_chk = 0;
    int n_fail = 0;

    // Bench model of the programmed state
    logic [7:0]  m_route [32];
    logic [31:0] m_en = '0, m_pol = '0, m_edge = '0, m_lat = '0, m_in = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rlic_top dut_i (
        .clk(clk), .rst_n(rst_n), .irq_src(irq_src), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_be(reg_be), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .par_irq(par_irq)
    );

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_active();
        return ((m_edge & m_lat) | (~m_edge & (m_in ^ m_pol))) & m_en;
    endfunction

    function automatic logic [31:0] exp_stat(input int c);
        logic [31:0] a, r;
        a = exp_active();
        for (int i = 0; i < 32; i++) r[i] = a[i] & m_route[i][c];
        return r;
    endfunction

    function automatic logic [3:0] exp_par();
        logic [31:0] a;
        logic [3:0] r;
        a = exp_active();
        r = '0;
        for (int i = 0; i < 32; i++) r = r | (a[i] ? m_route[i][7:4] : 4'h0);
        return r;
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        logic [31:0] r;
        r = '0;
        if (a[1:0] == 2'b00) begin
            if (a < 8'h20) for (int b = 0; b < 4; b++) r[8*b +: 8] = m_route[a[7:2]*4 + b];
            else if (a == 8'h24) r = m_en;
            else if (a == 8'h30) r = m_pol;
            else if (a == 8'h34) r = m_edge;
            else if (a == 8'h40) r = exp_stat(0);
            else if (a == 8'h48) r = exp_stat(1);
            else if (a == 8'h50) r = exp_stat(2);
            else if (a == 8'h58) r = exp_stat(3);
        end
        return r;
    endfunction

    // Register write with model update; returns after state has settled
    task automatic wr(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) m[8*b +: 8] = be[b] ? d[8*b +: 8] : 8'h00;
        if (a[1:0] == 2'b00) begin
            if (a < 8'h20) begin
                for (int b = 0; b < 4; b++) if (be[b]) m_route[a[7:2]*4 + b] = d[8*b +: 8];
            end else if (a == 8'h28) m_en = m_en | m;
            else if (a == 8'h2C) begin m_en = m_en & ~m; m_lat = m_lat & ~m; end
            else if (a == 8'h30) begin
                for (int b = 0; b < 4; b++) if (be[b]) m_pol[8*b +: 8] = d[8*b +: 8];
            end else if (a == 8'h34) begin
                for (int b = 0; b < 4; b++) if (be[b]) m_edge[8*b +: 8] = d[8*b +: 8];
                m_lat = m_lat & m_edge;
            end
        end
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_be = be; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_be = '0; reg_wdata = '0;
        cycles(2);
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    // Drive new input values, model selected edges, wait for synchronisation
    task automatic set_in(input logic [31:0] v);
        logic [31:0] rise, fall;
        rise = v & ~m_in;
        fall = ~v & m_in;
        m_lat = m_lat | (m_edge & ((m_pol & fall) | (~m_pol & rise)));
        m_in = v;
        @(negedge clk);
        irq_src = v;
        cycles(4);
    endtask

    task automatic check_all(input string tag);
        logic [31:0] d;
        for (int c = 0; c < 4; c++) begin
            rd(8'h40 + 8'(8*c), d);
            chk(d == exp_stat(c), {"R8 status ", tag}, d, exp_stat(c));
        end
        rd(8'h24, d);
        chk(d == m_en, {"R3 enable ", tag}, d, m_en);
        chk(par_irq == exp_par(), {"R9 parent ", tag}, {28'h0, par_irq}, {28'h0, exp_par()});
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [7:0] a;
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 32; i++) m_route[i] = 8'h00;
        cycles(3);
        rst_n = 1'b1;
        cycles(2);

        // R1: reset state
        for (int w = 0; w < 8; w++) begin
            rd(8'(4*w), d);
            chk(d == 32'h0, "R1 route reset", d, 32'h0);
        end
        rd(8'h24, d); chk(d == 32'h0, "R1 enable reset", d, 32'h0);
        rd(8'h30, d); chk(d == 32'h0, "R1 polarity reset", d, 32'h0);
        rd(8'h34, d); chk(d == 32'h0, "R1 edge reset", d, 32'h0);
        chk(par_irq == 4'h0, "R1 parent reset", {28'h0, par_irq}, 32'h0);

        // R2: partial lane write
        wr(8'h00, 4'b0101, 32'h11223344);
        rd(8'h00, d); chk(d == 32'h00220044, "R2 lane write", d, 32'h00220044);
        wr(8'h1C, 4'b1000, 32'hA5000000);
        rd(8'h1C, d); chk(d == 32'hA5000000, "R2 source 31 byte", d, 32'hA5000000);

        // R3 / R4: set and clear leave zero bits alone
        wr(8'h28, 4'hF, 32'h000000F0);
        wr(8'h28, 4'hF, 32'h0000000F);
        rd(8'h24, d); chk(d == 32'h000000FF, "R3 set accumulates", d, 32'h000000FF);
        wr(8'h2C, 4'hF, 32'h0000003C);
        rd(8'h24, d); chk(d == 32'h000000C3, "R4 clear selective", d, 32'h000000C3);
        wr(8'h2C, 4'hF, 32'hFFFFFFFF);

        // R5: level latency through the synchroniser
        wr(8'h00, 4'b1000, 32'h11000000);   // source 3 -> core 0, parent 0
        wr(8'h28, 4'hF, 32'h00000008);
        @(negedge clk); irq_src[3] = 1'b1;
        @(negedge clk);
        chk(par_irq[0] == 1'b0, "R5 one edge not yet", {31'h0, par_irq[0]}, 32'h0);
        @(negedge clk);
        chk(par_irq[0] == 1'b1, "R5 two edges visible", {31'h0, par_irq[0]}, 32'h1);
        m_in[3] = 1'b1;
        cycles(3);
        wr(8'h30, 4'b0001, 32'h00000008);   // invert: now idle
        chk(par_irq[0] == 1'b0, "R5 polarity inverts", {31'h0, par_irq[0]}, 32'h0);
        set_in(32'h0);
        chk(par_irq[0] == 1'b1, "R5 active low", {31'h0, par_irq[0]}, 32'h1);
        check_all("level");

        // R6: rising and falling edge latches
        wr(8'h04, 4'b0010, 32'h00002400);   // source 5 -> core 2, parent 1
        wr(8'h04, 4'b0100, 32'h00880000);   // source 6 -> core 3, parent 3
        wr(8'h30, 4'b0001, 32'h00000048);   // pol: source 3,6 inverted
        wr(8'h34, 4'b0001, 32'h00000060);
        wr(8'h28, 4'hF, 32'h00000060);
        set_in(32'h00000060);
        chk(par_irq[1] == 1'b1, "R6 rising caught", {31'h0, par_irq[1]}, 32'h1);
        chk(par_irq[3] == 1'b0, "R6 falling not on rise", {31'h0, par_irq[3]}, 32'h0);
        set_in(32'h00000000);
        chk(par_irq[1] == 1'b1, "R6 latch holds", {31'h0, par_irq[1]}, 32'h1);
        chk(par_irq[3] == 1'b1, "R6 falling caught", {31'h0, par_irq[3]}, 32'h1);
        check_all("edge");

        // R7: clear drops the latch, re-enable does not restore it
        wr(8'h2C, 4'hF, 32'h00000020);
        wr(8'h28, 4'hF, 32'h00000020);
        chk(par_irq[1] == 1'b0, "R7 latch cleared", {31'h0, par_irq[1]}, 32'h0);
        wr(8'h34, 4'b0001, 32'h00000020);  // source 6 to level: latch dropped
        wr(8'h34, 4'b0001, 32'h00000060);
        chk(par_irq[3] == 1'b0, "R7 level mode drops latch", {31'h0, par_irq[3]}, 32'h0);
        check_all("clear");

        // R10: unmapped reads and ignored writes
        rd(8'h20, d); chk(d == 32'h0, "R10 read 0x20", d, 32'h0);
        rd(8'h28, d); chk(d == 32'h0, "R10 read set reg", d, 32'h0);
        rd(8'h44, d); chk(d == 32'h0, "R10 read gap", d, 32'h0);
        rd(8'h01, d); chk(d == 32'h0, "R10 misaligned read", d, 32'h0);
        rd(8'hFC, d); chk(d == 32'h0, "R10 read top", d, 32'h0);
        wr(8'h24, 4'hF, 32'hFFFFFFFF);
        wr(8'h40, 4'hF, 32'hFFFFFFFF);
        wr(8'h29, 4'hF, 32'hFFFFFFFF);
        wr(8'h38, 4'hF, 32'hFFFFFFFF);
        rd(8'h24, d); chk(d == m_en, "R10 enable untouched", d, m_en);
        rd(8'h00, d); chk(d == exp_read(8'h00), "R10 route untouched", d, exp_read(8'h00));

        // R11: bitmap readback with lane merge
        wr(8'h30, 4'b1100, 32'hABCD0000);
        rd(8'h30, d); chk(d == m_pol, "R11 polarity readback", d, m_pol);
        rd(8'h34, d); chk(d == m_edge, "R11 edge readback", d, m_edge);

        // Seeded random phase
        for (int i = 0; i < 32; i += 4)
            wr(8'(i), 4'hF, $urandom());
        for (int it = 0; it < 150; it++) begin
            case ($urandom_range(0, 6))
                0: wr(8'(4 * $urandom_range(0, 7)), 4'($urandom()), $urandom());
                1: wr(8'h28, 4'($urandom()), $urandom());
                2: wr(8'h2C, 4'($urandom()), $urandom() & $urandom());
                3: wr(8'h30, 4'($urandom()), $urandom());
                4: wr(8'h34, 4'($urandom()), $urandom());
                default: set_in($urandom());
            endcase
            check_all("random");
            a = 8'($urandom());
            rd(a, d);
            chk(d == exp_read(a), "R2 R10 R11 random read", d, exp_read(a));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule